// File: doc/BRIEF.md
# Multichannel Time-Shared State-Variable Filter

This block runs one two-integrator state-variable filter over a large number of independent audio channels. It takes one sample per clock. The sample carries a channel number, and the channel number selects that channel's stored state and coefficients. A single arithmetic datapath is shared by all channels.

For each sample the block produces four responses: highpass, bandpass, lowpass and notch. They come out together with the channel tag and a valid strobe. The two integrator values of each channel are kept in a dual-port state memory. One port writes back the finished channel while the other port reads the state of a newer channel in the same clock. The cutoff and damping coefficients sit in a second memory, loaded through a plain write port.

A small controller has two states, CLEAR and RUN.
- Reset puts the controller in CLEAR.
- In CLEAR it sweeps every channel address and zeroes both memories, one address per clock.
- The transition from CLEAR to RUN happens on the clock that writes the last address.
- RUN holds until the next reset. Only in RUN are samples and coefficient writes taken.

The arithmetic is signed fixed point. Samples and integrator values are 16 bits. Coefficients are 16 bits with 14 fraction bits, so the value 16384 stands for 1.0.

Top module: `svf_multichannel`

## Requirements
- R1: While reset is held, `out_valid` and `init_done` are 0. After reset is released, `init_done` rises exactly CHANNELS clocks later and stays high until the next reset. At that point every channel's integrators, cutoff `f` and damping `q` are zero.
- R2: While `init_done` is 0, `in_valid` is ignored: no output appears and no channel state changes. While `init_done` is 0, `cfg_we` is also ignored.
- R3: The highpass output is hp = sat(x − d2 − ((q·d1) >>> 14)). Here d1 and d2 are the channel's stored integrator values, and >>> is an arithmetic shift, which rounds toward minus infinity.
- R4: The bandpass output is bp = sat(d1 + ((f·hp) >>> 14)), and bp is stored as the channel's new d1.
- R5: The lowpass output is lp = sat(d2 + ((f·d1) >>> 14)), using the old d1, and lp is stored as the channel's new d2.
- R6: The notch output is sat(hp + lp).
- R7: A sample accepted on a clock edge has its results, its channel tag and `out_valid` present after the sixth rising edge, counting the accepting edge as the first. A new sample can be accepted on every clock. Outputs appear in acceptance order, and `out_valid` is never raised without an accepted sample.
- R8: A channel's state changes only through samples tagged with that channel. Samples for other channels leave it untouched.
- R9: `cfg_we` with `cfg_ch`, `cfg_f` and `cfg_q` sets that channel's coefficients. Every sample accepted on a later edge uses the new values.
- R10: sat() clamps to the 16-bit signed range [−32768, 32767]. Stored state is always a clamped value.
- R11: A channel may be issued again six clocks after its previous sample, and that sample sees the state written back by the previous one. Issuing it again sooner is not allowed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high; starts the CLEAR sweep |
| in_valid | input | 1 | Sample strobe |
| in_ch | input | 9 | Channel number of the sample |
| in_x | input | 16 | Signed input sample |
| cfg_we | input | 1 | Coefficient write strobe |
| cfg_ch | input | 9 | Channel whose coefficients are written |
| cfg_f | input | 16 | Cutoff coefficient, signed, 14 fraction bits |
| cfg_q | input | 16 | Damping coefficient, signed, 14 fraction bits |
| init_done | output | 1 | High in RUN state |
| out_valid | output | 1 | Result strobe |
| out_ch | output | 9 | Channel tag of the result |
| out_hp | output | 16 | Highpass response |
| out_bp | output | 16 | Bandpass response |
| out_lp | output | 16 | Lowpass response |
| out_notch | output | 16 | Notch response |

## Verification
Each of the four responses and the channel tag is due after the sixth rising edge, counting the edge that accepts the sample. The bench stamps every issued sample with the edge count. When an output appears, it checks that exactly six edges have passed, and it samples on the falling edge.

`init_done` is due CHANNELS edges after reset release, and the bench counts that span edge by edge.

Two other timings are checked. A coefficient write lands on one edge, and the bench sends the sample on a later edge. A channel re-issued after six edges must see its own write-back; the bench checks this with a hand-computed four-sample chain.

// File: rtl/svf_pkg.sv
package svf_pkg;

    localparam int SVF_CHANNELS = 512;
    localparam int SVF_DW       = 16;
    localparam int SVF_CW       = 16;
    localparam int SVF_FRAC     = 14;

    typedef enum logic [0:0] {
        ST_CLEAR = 1'b0,
        ST_RUN   = 1'b1
    } svf_state_e;

endpackage

// File: rtl/svf_ram.sv
module svf_ram #(
    parameter int WIDTH = 32,
    parameter int DEPTH = 512,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             we,
    input  logic [AW-1:0]    waddr,
    input  logic [WIDTH-1:0] wdata,
    input  logic [AW-1:0]    raddr,
    output logic [WIDTH-1:0] rdata
);

    logic [WIDTH-1:0] mem [DEPTH];

    // write port and registered read port; a same-address read returns old data
    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
        rdata <= mem[raddr];
    end

endmodule

// File: rtl/svf_init_ctrl.sv
module svf_init_ctrl
    import svf_pkg::*;
#(
    parameter int CHANNELS = SVF_CHANNELS,
    localparam int AW      = $clog2(CHANNELS)
) (
    input  logic          clk,
    input  logic          rst,
    output logic          init_done,
    output logic          clr_we,
    output logic [AW-1:0] clr_addr
);

    localparam logic [AW-1:0] LAST_ADDR = AW'(CHANNELS - 1);

    svf_state_e state, state_nxt;

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_CLEAR;
        end else begin
            state <= state_nxt;
        end
    end

    // sweep address
    always_ff @(posedge clk) begin
        if (rst) begin
            clr_addr <= '0;
        end else if (state == ST_CLEAR) begin
            clr_addr <= clr_addr + 1'b1;
        end
    end

    // next state
    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_CLEAR: if (clr_addr == LAST_ADDR) state_nxt = ST_RUN;
            ST_RUN:   state_nxt = ST_RUN;
        endcase
    end

    // outputs
    always_comb begin
        init_done = 1'b0;
        clr_we    = 1'b0;
        unique case (state)
            ST_CLEAR: clr_we    = 1'b1;
            ST_RUN:   init_done = 1'b1;
        endcase
    end

    assert_ready_sticky_R1: assert property (@(posedge clk) disable iff (rst)
        init_done |=> init_done);

    assert_full_sweep_R1: assert property (@(posedge clk) disable iff (rst)
        $rose(init_done) |-> $past(clr_addr) == LAST_ADDR);

endmodule

// File: rtl/svf_datapath.sv
module svf_datapath
    import svf_pkg::*;
#(
    parameter int CHANNELS = SVF_CHANNELS,
    parameter int DW       = SVF_DW,
    parameter int CW       = SVF_CW,
    parameter int FRAC     = SVF_FRAC,
    localparam int CHW     = $clog2(CHANNELS),
    localparam int PW      = DW + CW,
    localparam int ACCW    = PW + 2,
    localparam int NSTG    = 5
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  acc_valid,
    input  logic [CHW-1:0]        acc_ch,
    input  logic signed [DW-1:0]  acc_x,
    input  logic [2*DW-1:0]       st_rdata,
    input  logic [2*CW-1:0]       cf_rdata,
    output logic                  wr_en,
    output logic [CHW-1:0]        wr_addr,
    output logic [2*DW-1:0]       wr_data,
    output logic                  out_valid,
    output logic [CHW-1:0]        out_ch,
    output logic signed [DW-1:0]  out_hp,
    output logic signed [DW-1:0]  out_bp,
    output logic signed [DW-1:0]  out_lp,
    output logic signed [DW-1:0]  out_notch
);

    localparam logic signed [DW-1:0]   SAT_MAX = {1'b0, {(DW-1){1'b1}}};
    localparam logic signed [DW-1:0]   SAT_MIN = {1'b1, {(DW-1){1'b0}}};
    localparam logic signed [ACCW-1:0] SAT_HI  = ACCW'(SAT_MAX);
    localparam logic signed [ACCW-1:0] SAT_LO  = ACCW'(SAT_MIN);

    function automatic logic signed [DW-1:0] clamp(input logic signed [ACCW-1:0] v);
        if (v > SAT_HI) return SAT_MAX;
        else if (v < SAT_LO) return SAT_MIN;
        else return v[DW-1:0];
    endfunction

    // tag pipeline: valid and channel follow the data through stages 1..5
    logic [NSTG-1:0] vld;
    logic [CHW-1:0]  chn [NSTG];

    always_ff @(posedge clk) begin
        if (rst) vld[0] <= 1'b0;
        else     vld[0] <= acc_valid;
        chn[0] <= acc_ch;
    end

    generate
        for (genvar i = 1; i < NSTG; i++) begin : g_tag
            always_ff @(posedge clk) begin
                if (rst) vld[i] <= 1'b0;
                else     vld[i] <= vld[i-1];
                chn[i] <= chn[i-1];
            end
        end
    endgenerate

    // stage 1: memory read data arrives alongside the sample
    logic signed [DW-1:0] x1;
    logic signed [DW-1:0] rd_d1, rd_d2;
    logic signed [CW-1:0] rd_f, rd_q;

    always_ff @(posedge clk) x1 <= acc_x;

    always_comb begin
        rd_d1 = st_rdata[2*DW-1:DW];
        rd_d2 = st_rdata[DW-1:0];
        rd_f  = cf_rdata[2*CW-1:CW];
        rd_q  = cf_rdata[CW-1:0];
    end

    // stage 2: damping and lowpass products
    logic signed [DW-1:0] x2, d1_2, d2_2;
    logic signed [CW-1:0] f2;
    logic signed [PW-1:0] pq2, pf2;

    always_ff @(posedge clk) begin
        x2   <= x1;
        d1_2 <= rd_d1;
        d2_2 <= rd_d2;
        f2   <= rd_f;
        pq2  <= PW'(rd_q) * PW'(rd_d1);
        pf2  <= PW'(rd_f) * PW'(rd_d1);
    end

    // stage 3: highpass and lowpass
    logic signed [ACCW-1:0] hp_sum, lp_sum;
    logic signed [DW-1:0]   hp3, lp3, d1_3;
    logic signed [CW-1:0]   f3;

    always_comb begin
        hp_sum = ACCW'(x2) - ACCW'(d2_2) - ACCW'(pq2 >>> FRAC);
        lp_sum = ACCW'(d2_2) + ACCW'(pf2 >>> FRAC);
    end

    always_ff @(posedge clk) begin
        hp3  <= clamp(hp_sum);
        lp3  <= clamp(lp_sum);
        d1_3 <= d1_2;
        f3   <= f2;
    end

    // stage 4: bandpass product
    logic signed [PW-1:0] pfh4;
    logic signed [DW-1:0] hp4, lp4, d1_4;

    always_ff @(posedge clk) begin
        pfh4 <= PW'(f3) * PW'(hp3);
        hp4  <= hp3;
        lp4  <= lp3;
        d1_4 <= d1_3;
    end

    // stage 5: bandpass and notch, feeding the write-back
    logic signed [ACCW-1:0] bp_sum, nt_sum;
    logic signed [DW-1:0]   hp5, lp5, bp5, nt5;

    always_comb begin
        bp_sum = ACCW'(d1_4) + ACCW'(pfh4 >>> FRAC);
        nt_sum = ACCW'(hp4) + ACCW'(lp4);
    end

    always_ff @(posedge clk) begin
        bp5 <= clamp(bp_sum);
        nt5 <= clamp(nt_sum);
        hp5 <= hp4;
        lp5 <= lp4;
    end

    assign wr_en   = vld[NSTG-1];
    assign wr_addr = chn[NSTG-1];
    assign wr_data = {bp5, lp5};

    // stage 6: output register, same edge as the state write
    always_ff @(posedge clk) begin
        if (rst) out_valid <= 1'b0;
        else     out_valid <= vld[NSTG-1];
        out_ch    <= chn[NSTG-1];
        out_hp    <= hp5;
        out_bp    <= bp5;
        out_lp    <= lp5;
        out_notch <= nt5;
    end

    assert_latency_R7: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> $past(acc_valid, 6));

    assert_tag_latency_R7: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> out_ch == $past(acc_ch, 6));

    assert_bp_clamp_R10: assert property (@(posedge clk) disable iff (rst)
        (vld[3] && bp_sum > SAT_HI) |=> bp5 == SAT_MAX);

    generate
        for (genvar i = 0; i < NSTG; i++) begin : g_spacing
            assert_channel_spacing_R11: assert property (@(posedge clk) disable iff (rst)
                (acc_valid && vld[i]) |-> chn[i] != acc_ch);
        end
    endgenerate

endmodule

// File: rtl/svf_multichannel.sv
module svf_multichannel
    import svf_pkg::*;
#(
    parameter int CHANNELS = SVF_CHANNELS,
    parameter int DW       = SVF_DW,
    parameter int CW       = SVF_CW,
    parameter int FRAC     = SVF_FRAC,
    localparam int CHW     = $clog2(CHANNELS)
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  in_valid,
    input  logic [CHW-1:0]        in_ch,
    input  logic signed [DW-1:0]  in_x,
    input  logic                  cfg_we,
    input  logic [CHW-1:0]        cfg_ch,
    input  logic signed [CW-1:0]  cfg_f,
    input  logic signed [CW-1:0]  cfg_q,
    output logic                  init_done,
    output logic                  out_valid,
    output logic [CHW-1:0]        out_ch,
    output logic signed [DW-1:0]  out_hp,
    output logic signed [DW-1:0]  out_bp,
    output logic signed [DW-1:0]  out_lp,
    output logic signed [DW-1:0]  out_notch
);

    logic           clr_we;
    logic [CHW-1:0] clr_addr;
    logic           accept;

    logic           dp_wr_en;
    logic [CHW-1:0] dp_wr_addr;
    logic [2*DW-1:0] dp_wr_data;

    logic            st_we, cf_we;
    logic [CHW-1:0]  st_waddr, cf_waddr;
    logic [2*DW-1:0] st_wdata, st_rdata;
    logic [2*CW-1:0] cf_wdata, cf_rdata;

    svf_init_ctrl #(.CHANNELS(CHANNELS)) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .init_done (init_done),
        .clr_we    (clr_we),
        .clr_addr  (clr_addr)
    );

    assign accept = in_valid & init_done;

    // the clear sweep owns both write ports until RUN
    always_comb begin
        st_we    = clr_we | dp_wr_en;
        st_waddr = clr_we ? clr_addr : dp_wr_addr;
        st_wdata = clr_we ? '0 : dp_wr_data;
        cf_we    = clr_we | (cfg_we & init_done);
        cf_waddr = clr_we ? clr_addr : cfg_ch;
        cf_wdata = clr_we ? '0 : {cfg_f, cfg_q};
    end

    svf_ram #(.WIDTH(2*DW), .DEPTH(CHANNELS)) u_state_ram (
        .clk   (clk),
        .we    (st_we),
        .waddr (st_waddr),
        .wdata (st_wdata),
        .raddr (in_ch),
        .rdata (st_rdata)
    );

    svf_ram #(.WIDTH(2*CW), .DEPTH(CHANNELS)) u_coef_ram (
        .clk   (clk),
        .we    (cf_we),
        .waddr (cf_waddr),
        .wdata (cf_wdata),
        .raddr (in_ch),
        .rdata (cf_rdata)
    );

    svf_datapath #(
        .CHANNELS (CHANNELS),
        .DW       (DW),
        .CW       (CW),
        .FRAC     (FRAC)
    ) u_dp (
        .clk       (clk),
        .rst       (rst),
        .acc_valid (accept),
        .acc_ch    (in_ch),
        .acc_x     (in_x),
        .st_rdata  (st_rdata),
        .cf_rdata  (cf_rdata),
        .wr_en     (dp_wr_en),
        .wr_addr   (dp_wr_addr),
        .wr_data   (dp_wr_data),
        .out_valid (out_valid),
        .out_ch    (out_ch),
        .out_hp    (out_hp),
        .out_bp    (out_bp),
        .out_lp    (out_lp),
        .out_notch (out_notch)
    );

    assert_no_write_clash_R1: assert property (@(posedge clk) disable iff (rst)
        clr_we |-> !dp_wr_en);

    assert_quiet_until_ready_R2: assert property (@(posedge clk) disable iff (rst)
        !init_done |-> !out_valid);

endmodule

// File: tb/sim_svf_multichannel.sv
`timescale 1ns/1ps
module sim_svf_multichannel;
    import svf_pkg::*;

    localparam int CH  = SVF_CHANNELS;
    localparam int DW  = SVF_DW;
    localparam int CW  = SVF_CW;
    localparam int CHW = $clog2(CH);
    localparam int LAT = 6;
    localparam int NV  = 16;

    // stimulus table: channel and sample, channels spaced eight apart
    localparam int TB_CH [NV] = '{0, 1, 2, 3, 4, 5, 6, 7, 0, 1, 2, 3, 4, 5, 6, 7};
    localparam int TB_X  [NV] = '{1000, -1000, 32767, -32768, 0, 12345, -2222, 500,
                                  800, 32767, -32768, 4000, -7, 20000, 1, -15000};

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic in_valid = 1'b0;
    logic [CHW-1:0] in_ch = '0;
    logic signed [DW-1:0] in_x = '0;
    logic cfg_we = 1'b0;
    logic [CHW-1:0] cfg_ch = '0;
    logic signed [CW-1:0] cfg_f = '0;
    logic signed [CW-1:0] cfg_q = '0;
    logic init_done, out_valid;
    logic [CHW-1:0] out_ch;
    logic signed [DW-1:0] out_hp, out_bp, out_lp, out_notch;

    always #4 clk = ~clk;

    svf_multichannel u0 (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ch(in_ch), .in_x(in_x),
        .cfg_we(cfg_we), .cfg_ch(cfg_ch), .cfg_f(cfg_f), .cfg_q(cfg_q),
        .init_done(init_done), .out_valid(out_valid), .out_ch(out_ch),
        .out_hp(out_hp), .out_bp(out_bp), .out_lp(out_lp), .out_notch(out_notch)
    );

    int n_chk = 0;
    int n_fail = 0;
    longint cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(bit ok, string req, longint act, longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // reference state
    longint md1 [CH];
    longint md2 [CH];
    longint mf  [CH];
    longint mq  [CH];
    longint e_hp [256], e_bp [256], e_lp [256], e_nt [256], e_ch [256], e_cyc [256];
    int wr_i = 0;
    int rd_i = 0;
    int out_seen = 0;
    longint last_hp, last_bp, last_lp, last_nt;
    int idx;

    function automatic longint sat(longint v);
        if (v > 32767) return 32767;
        if (v < -32768) return -32768;
        return v;
    endfunction

    task automatic model_clear();
        for (int i = 0; i < CH; i++) begin
            md1[i] = 0; md2[i] = 0; mf[i] = 0; mq[i] = 0;
        end
    endtask

    task automatic send(int ch, int x);
        longint hp, bp, lp;
        in_valid = 1'b1;
        in_ch = CHW'(ch);
        in_x = DW'(x);
        hp = sat(x - md2[ch] - ((mq[ch] * md1[ch]) >>> 14));
        lp = sat(md2[ch] + ((mf[ch] * md1[ch]) >>> 14));
        bp = sat(md1[ch] + ((mf[ch] * hp) >>> 14));
        e_hp[wr_i % 256] = hp;
        e_bp[wr_i % 256] = bp;
        e_lp[wr_i % 256] = lp;
        e_nt[wr_i % 256] = sat(hp + lp);
        e_ch[wr_i % 256] = ch;
        e_cyc[wr_i % 256] = cyc;
        wr_i++;
        md1[ch] = bp;
        md2[ch] = lp;
        @(negedge clk);
    endtask

    task automatic idle(int n);
        in_valid = 1'b0;
        repeat (n) @(negedge clk);
    endtask

    task automatic setcoef(int ch, int f, int q);
        cfg_we = 1'b1;
        cfg_ch = CHW'(ch);
        cfg_f = CW'(f);
        cfg_q = CW'(q);
        @(negedge clk);
        cfg_we = 1'b0;
        mf[ch] = f;
        mq[ch] = q;
    endtask

    // reset, optionally with ignored sample traffic during the sweep
    task automatic do_reset(bit busy_traffic);
        longint t0;
        int seen0;
        rst = 1'b1;
        in_valid = 1'b0;
        repeat (3) @(negedge clk);
        chk(out_valid == 1'b0, "R1 out_valid in reset", longint'(out_valid), 0);
        chk(init_done == 1'b0, "R1 init_done in reset", longint'(init_done), 0);
        rst = 1'b0;
        t0 = cyc;
        seen0 = out_seen;
        model_clear();
        if (busy_traffic) begin
            in_valid = 1'b1; in_ch = CHW'(12); in_x = DW'(777);
            cfg_we = 1'b1; cfg_ch = CHW'(12); cfg_f = CW'(9999); cfg_q = CW'(9999);
            repeat (10) @(negedge clk);
            in_valid = 1'b0;
            cfg_we = 1'b0;
        end
        while (!init_done && (cyc - t0) < CH + 20) @(negedge clk);
        chk(cyc - t0 == CH, "R1 sweep length", cyc - t0, CH);
        chk(out_seen == seen0, "R2 outputs during sweep", out_seen - seen0, 0);
    endtask

    // monitor: compares every result with its expected value and due edge
    always @(negedge clk) begin
        if (!rst && out_valid) begin
            out_seen++;
            if (rd_i == wr_i) begin
                chk(1'b0, "R7 output without accepted sample", longint'(out_ch), -1);
            end else begin
                idx = rd_i % 256;
                chk(longint'(out_ch) == e_ch[idx], "R7 channel tag", longint'(out_ch), e_ch[idx]);
                chk(cyc - e_cyc[idx] == LAT, "R7 latency", cyc - e_cyc[idx], LAT);
                chk(longint'(out_hp) == e_hp[idx], "R3 highpass", longint'(out_hp), e_hp[idx]);
                chk(longint'(out_bp) == e_bp[idx], "R4 bandpass", longint'(out_bp), e_bp[idx]);
                chk(longint'(out_lp) == e_lp[idx], "R5 lowpass", longint'(out_lp), e_lp[idx]);
                chk(longint'(out_notch) == e_nt[idx], "R6 notch", longint'(out_notch), e_nt[idx]);
                rd_i++;
            end
            last_hp = longint'(out_hp);
            last_bp = longint'(out_bp);
            last_lp = longint'(out_lp);
            last_nt = longint'(out_notch);
        end
    end

    task automatic run_all();
        @(negedge clk);
        do_reset(1'b1);

        // table walk, one sample per clock (R3..R8, R10 on the rails)
        for (int i = 0; i < 8; i++) setcoef(i, 2048 * (i + 1), 16384 - 1024 * i);
        for (int i = 0; i < NV; i++) send(TB_CH[i], TB_X[i]);
        idle(10);
        chk(rd_i == wr_i, "R7 all table results delivered", rd_i, wr_i);

        // R8: an untouched channel still starts from zero
        send(13, 250); idle(8);
        chk(last_hp == 250 && last_bp == 0 && last_lp == 0, "R8 untouched channel", last_hp, 250);

        // R2: sweep-time traffic left channel 12 at zero state and zero coefficients
        send(12, 500); idle(8);
        chk(last_hp == 500, "R2 state after ignored samples", last_hp, 500);
        chk(last_bp == 0, "R2 coefficients after ignored write", last_bp, 0);

        // R9: new cutoff takes effect
        setcoef(12, 16384, 0);
        send(12, 500); idle(8);
        chk(last_bp == 500, "R9 new cutoff used", last_bp, 500);

        // R11: re-issue every six clocks, hand-computed chain
        setcoef(9, 8192, 8192);
        for (int k = 0; k < 4; k++) begin send(9, 1000); idle(5); end
        idle(8);
        chk(last_hp == -202, "R11 chained highpass", last_hp, -202);
        chk(last_bp == 930, "R11 chained bandpass", last_bp, 930);
        chk(last_lp == 1202, "R11 chained lowpass", last_lp, 1202);
        chk(last_nt == 1000, "R11 chained notch", last_nt, 1000);

        // R10: clamp at both rails
        setcoef(10, 32767, 0);
        send(10, 30000); idle(8);
        chk(last_bp == 32767, "R10 positive clamp", last_bp, 32767);
        setcoef(11, 32767, 0);
        send(11, -30000); idle(8);
        chk(last_bp == -32768, "R10 negative clamp", last_bp, -32768);

        // R1: a second reset clears state and coefficients
        do_reset(1'b0);
        send(9, 100); idle(8);
        chk(last_hp == 100 && last_lp == 0 && last_bp == 0, "R1 state cleared", last_hp, 100);
        chk(rd_i == wr_i, "R7 all results delivered", rd_i, wr_i);
    endtask

    initial begin
        fork
            run_all();
            begin
                repeat (20000) @(posedge clk);
                chk(1'b0, "watchdog expired", cyc, 0);
            end
        join_any
        disable fork;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule